// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on one transmit line. A byte is taken over a valid/ready handshake, normally from a transmit FIFO. The block wraps it in a low start bit, sends 5 to 8 data bits least significant bit first, adds an optional parity bit, and closes with one or two high stop bits. The word length, parity mode and stop count are inputs that can change at run time. They are captured together with the byte at the moment it is accepted, so a frame already on the line keeps its format.

Bit timing comes from an external enable, `baud_tick`, that pulses at sixteen times the bit rate. Every bit on the line lasts exactly sixteen of these pulses, however many clocks lie between them. A separate break request drives the line low for as long as the request is held. A frame that is already being sent is finished before the break starts.

The reset input is asynchronous and active low. It is expected to be released in step with `clk` by the reset logic outside the block.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset and whenever no frame or break is in progress, `tx_out` is 1 and `busy` is 0.
- R2: A byte is accepted at a rising clock edge where `in_valid` and `in_ready` are both 1. `tx_out` shows the start bit (0) from the next cycle. Every bit of the frame lasts exactly 16 `baud_tick` pulses, and clocks without a pulse do not advance it.
- R3: Data bits go out least significant bit first. `cfg_wlen` gives their number: 00 = 5, 01 = 6, 10 = 7, 11 = 8. Bits of `in_data` above the selected length are not sent.
- R4: With `cfg_par_en` = 1, one parity bit follows the data. If `cfg_par_stick` = 0, it is the XOR of the sent data bits when `cfg_par_odd` = 0 (even parity) and its inverse when `cfg_par_odd` = 1 (odd parity). If `cfg_par_stick` = 1, the bit equals `cfg_par_odd`. With `cfg_par_en` = 0, no parity bit is sent.
- R5: The frame ends with one stop bit at 1 when `cfg_stop2` = 0, and with two when `cfg_stop2` = 1.
- R6: `busy` is 1 from the cycle after acceptance until the last stop bit has lasted its 16 ticks. It is 0 at all other times.
- R7: Data and configuration are sampled only at acceptance. Changing them during a frame has no effect on the bits being sent.
- R8: While `brk_req` is 1 and no frame is in progress, `in_ready` is 0. `tx_out` goes to 0 one cycle after `brk_req` is first sampled high and stays 0 while it is held. It returns to 1 one cycle after `brk_req` is sampled low.
- R9: A break requested during a frame does not change that frame. When its last stop bit ends with `brk_req` still high, `tx_out` goes straight to 0 with no idle cycle.
- R10: `in_ready` is 1 in the first cycle after a frame's last stop bit ends, if `brk_req` is 0. A byte held valid is then accepted in that cycle, so back-to-back frames have a one-clock idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Enable pulse at 16 times the bit rate |
| in_valid | input | 1 | A byte is offered |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | The block can take a byte this cycle |
| cfg_wlen | input | 2 | Data bit count: 00=5, 01=6, 10=7, 11=8 |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_odd | input | 1 | Odd parity, or the value of the stick bit |
| cfg_par_stick | input | 1 | Send a constant parity bit |
| cfg_stop2 | input | 1 | Two stop bits instead of one |
| brk_req | input | 1 | Hold the line low (break) |
| tx_out | output | 1 | Serial line, idle high |
| busy | output | 1 | A frame is on the line |

## Verification
`tx_out` and `busy` change one clock after the edge that causes them: the edge where a byte is accepted, the edge that samples the 16th `baud_tick` of a bit, or the edge where a break request is sampled. `in_ready` follows `brk_req` in the same cycle. The bench keeps a behavioural reference that advances at each rising edge on the same sampled inputs. It compares all three outputs one time unit after every falling edge, after the inputs for the coming edge are settled. Each rule is therefore checked in exactly the cycle it is due. The tick spacing is changed between runs, so the checks confirm that bit length counts ticks and not clocks.

// File: rtl/sftx_pkg.sv
`timescale 1ns/1ps
package sftx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_BREAK = 2'd2
  } sftx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_odd;
    logic       par_stick;
    logic       stop2;
  } sftx_cfg_t;

endpackage

// File: rtl/sftx_bit_timer.sv
`timescale 1ns/1ps
module sftx_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic baud_tick,
  output logic bit_done
);
  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (baud_tick) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_done = run & baud_tick & (cnt_q == LAST);

endmodule

// File: rtl/sftx_frame_builder.sv
`timescale 1ns/1ps
module sftx_frame_builder
  import sftx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEN_W   = 4
) (
  input  logic [DATA_W-1:0]  data,
  input  sftx_cfg_t          cfg,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);
  localparam int MIN_W = DATA_W - 3;

  int   nbits;
  logic ones;
  logic par_bit;

  always_comb begin
    nbits = MIN_W + int'(cfg.wlen);
    frame = '1;
    frame[0] = 1'b0;
    ones = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nbits) begin
        frame[i+1] = data[i];
        ones = ones ^ data[i];
      end
    end
    par_bit = cfg.par_stick ? cfg.par_odd : (ones ^ cfg.par_odd);
    for (int p = 0; p < FRAME_W; p++) begin
      if (cfg.par_en && (p == nbits + 1)) frame[p] = par_bit;
    end
    len = LEN_W'(nbits + 2 + int'(cfg.par_en) + int'(cfg.stop2));
  end

endmodule

// File: rtl/sftx_shift_reg.sv
`timescale 1ns/1ps
module sftx_shift_reg #(
  parameter int FRAME_W = 12,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   len_in,
  output logic               head_next,
  output logic               last
);
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [LEN_W-1:0]   left_q, left_d;

  always_comb begin
    frame_d = frame_q;
    left_d  = left_q;
    if (load) begin
      frame_d = frame_in;
      left_d  = len_in;
    end else if (shift) begin
      frame_d = {1'b1, frame_q[FRAME_W-1:1]};
      left_d  = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
    end else begin
      frame_q <= frame_d;
      left_q  <= left_d;
    end
  end

  assign head_next = frame_d[0];
  assign last      = (left_q == LEN_W'(1));

  // R5: the sequencer never shifts beyond the final stop bit
  assert_no_underrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (left_q != '0));

  // R6: a new frame is loaded only after the previous one has fully drained
  assert_drained_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (left_q == '0));

endmodule

// File: rtl/serial_frame_tx.sv
`timescale 1ns/1ps
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_par_stick,
  input  logic              cfg_stop2,
  input  logic              brk_req,
  output logic              tx_out,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  sftx_state_e        st_q, st_d;
  logic               tx_q, tx_d;
  logic               load, shift, run, bit_done, last, head_next;
  sftx_cfg_t          cfg;
  logic [FRAME_W-1:0] frame_new;
  logic [LEN_W-1:0]   len_new;

  assign cfg = '{wlen: cfg_wlen, par_en: cfg_par_en, par_odd: cfg_par_odd,
                 par_stick: cfg_par_stick, stop2: cfg_stop2};

  assign run      = (st_q == ST_SEND);
  assign in_ready = (st_q == ST_IDLE) & ~brk_req;
  assign busy     = run;
  assign tx_out   = tx_q;

  sftx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(run), .baud_tick(baud_tick), .bit_done(bit_done)
  );

  sftx_frame_builder #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) build_i (
    .data(in_data), .cfg(cfg), .frame(frame_new), .len(len_new)
  );

  sftx_shift_reg #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) shreg_i (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .frame_in(frame_new), .len_in(len_new), .head_next(head_next), .last(last)
  );

  always_comb begin
    st_d  = st_q;
    load  = 1'b0;
    shift = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (brk_req) begin
          st_d = ST_BREAK;
        end else if (in_valid) begin
          load = 1'b1;
          st_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (bit_done) begin
          shift = 1'b1;
          if (last) st_d = brk_req ? ST_BREAK : ST_IDLE;
        end
      end
      ST_BREAK: begin
        if (!brk_req) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      ST_SEND:  tx_d = head_next;
      ST_BREAK: tx_d = 1'b0;
      default:  tx_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      tx_q <= 1'b1;
    end else begin
      st_q <= st_d;
      tx_q <= tx_d;
    end
  end

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> tx_out);

  assert_start_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !tx_out));

  assert_bit_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bit_done) |=> $stable(tx_out));

  assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && bit_done && last) |-> tx_out);

  assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BREAK) |-> !tx_out);

  assert_break_follows_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && bit_done && last && brk_req) |=> (!busy && !tx_out));

endmodule

// File: tb/serial_frame_tx_tb_top.sv
`timescale 1ns/1ps
module serial_frame_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic [1:0] cfg_wlen;
  logic       cfg_par_en, cfg_par_odd, cfg_par_stick, cfg_stop2;
  logic       brk_req;
  logic       tx_out, busy;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    tick_div = 1;
  bit    done = 1'b0;
  string ovr = "";

  // reference model state: 0 idle, 1 sending, 2 break
  int    m_st;
  int    m_tk;
  logic  m_tx;
  bit    q_bits[$];
  string q_tag[$];

  always #4 clk = ~clk;

  serial_frame_tx #(.DATA_W(8), .TICKS_PER_BIT(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_par_stick(cfg_par_stick), .cfg_stop2(cfg_stop2),
    .brk_req(brk_req), .tx_out(tx_out), .busy(busy)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic build_frame();
    int n;
    int ones;
    n = 5 + int'(cfg_wlen);
    ones = 0;
    q_bits.push_back(1'b0); q_tag.push_back("R2");
    for (int i = 0; i < n; i++) begin
      q_bits.push_back(in_data[i]); q_tag.push_back("R3");
      ones += int'(in_data[i]);
    end
    if (cfg_par_en) begin
      if (cfg_par_stick) q_bits.push_back(cfg_par_odd);
      else               q_bits.push_back(((ones % 2) == 1) ^ cfg_par_odd);
      q_tag.push_back("R4");
    end
    q_bits.push_back(1'b1); q_tag.push_back("R5");
    if (cfg_stop2) begin q_bits.push_back(1'b1); q_tag.push_back("R5"); end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tk = 0; m_tx = 1'b1;
      q_bits.delete(); q_tag.delete();
    end else begin
      case (m_st)
        0: begin
          if (brk_req) begin m_st = 2; m_tx = 1'b0; end
          else if (in_valid) begin
            build_frame();
            m_st = 1; m_tk = 0; m_tx = q_bits[0];
          end
        end
        1: begin
          if (baud_tick) begin
            m_tk++;
            if (m_tk == 16) begin
              m_tk = 0;
              void'(q_bits.pop_front());
              void'(q_tag.pop_front());
              if (q_bits.size() == 0) begin
                if (brk_req) begin m_st = 2; m_tx = 1'b0; end
                else begin m_st = 0; m_tx = 1'b1; end
              end else begin
                m_tx = q_bits[0];
              end
            end
          end
        end
        default: if (!brk_req) begin m_st = 0; m_tx = 1'b1; end
      endcase
    end
  end

  always @(negedge clk) begin
    cyc++;
    baud_tick <= ((cyc % tick_div) == 0);
  end

  always begin
    @(negedge clk);
    #1;
    if (rst_n && !done) begin
      string t_tx, t_bz, t_rd;
      t_tx = (m_st == 1) ? q_tag[0] : (m_st == 2) ? "R8" : "R1";
      t_bz = "R6";
      t_rd = brk_req ? "R8" : "R10";
      if (ovr != "") begin t_tx = ovr; t_bz = ovr; t_rd = ovr; end
      chk(tx_out, m_tx, t_tx, "tx_out");
      chk(busy, (m_st == 1), t_bz, "busy");
      chk(in_ready, (m_st == 0) && !brk_req, t_rd, "in_ready");
    end
  end

  task automatic finish_sim();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                      input logic po, input logic ps, input logic s2, input bit hold);
    @(negedge clk);
    in_data = d; cfg_wlen = wl; cfg_par_en = pe; cfg_par_odd = po;
    cfg_par_stick = ps; cfg_stop2 = s2; in_valid = 1'b1;
    forever begin
      #2;
      if (in_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    if (!hold) in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_st != 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; cfg_wlen = 2'b11;
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_par_stick = 1'b0; cfg_stop2 = 1'b0;
    brk_req = 1'b0; baud_tick = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(tx_out, 1'b1, "R1", "reset tx_out");
    chk(busy, 1'b0, "R1", "reset busy");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R5: plain 8-bit, no parity, one stop
    send(8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); wait_idle();
    // R3: every word length, upper bits must be dropped
    for (int w = 0; w < 4; w++) begin
      send(8'hE6 ^ 8'(w), 2'(w), 1'b1, 1'b0, 1'b0, 1'(w % 2), 1'b0); wait_idle();
    end
    // R4: even and odd parity on several values
    send(8'h3C, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); wait_idle();
    send(8'h01, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); wait_idle();
    send(8'h1F, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0); wait_idle();
    // R4: stick parity at both levels
    send(8'h55, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); wait_idle();
    send(8'h55, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); wait_idle();
    // R2: sparse ticks, bit length counts ticks not clocks
    tick_div = 3;
    send(8'h96, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); wait_idle();
    tick_div = 1;
    // R7: scramble data and configuration during a frame
    ovr = "R7";
    send(8'hC3, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    in_data = 8'h3C; cfg_wlen = 2'b00; cfg_par_en = 1'b0; cfg_par_stick = 1'b1;
    cfg_par_odd = 1'b1; cfg_stop2 = 1'b1;
    wait_idle();
    ovr = "";
    // R8: break from idle
    @(negedge clk); brk_req = 1'b1;
    repeat (40) @(negedge clk);
    brk_req = 1'b0;
    wait_idle();
    // R8: break with a byte waiting, byte taken after release
    @(negedge clk); brk_req = 1'b1; in_valid = 1'b1; in_data = 8'h7E;
    cfg_wlen = 2'b11; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
    repeat (10) @(negedge clk);
    brk_req = 1'b0;
    do @(negedge clk); while (m_st != 1);
    in_valid = 1'b0;
    wait_idle();
    // R9: break requested during a frame
    ovr = "R9";
    send(8'h81, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (50) @(negedge clk);
    brk_req = 1'b1;
    do @(negedge clk); while (m_st != 2);
    repeat (20) @(negedge clk);
    brk_req = 1'b0;
    wait_idle();
    // R10: back-to-back frames with valid held high
    ovr = "R10";
    send(8'h5A, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send(8'hF0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    wait_idle();
    ovr = "";
    finish_sim();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

endmodule